// File: doc/BRIEF.md
# Instruction Flush and Sequential Count Tracker

This block follows a processor's execution progress from per-cycle status. It reads a fetch-type code and a flush count. From these it keeps a running count of the sequential instructions executed since the last reported branch. When a taken branch is signalled, it raises a branch message request that carries the count accumulated before the branch, tags the request with a rolling identifier, and starts counting again from zero.

Branches can later turn out to be wrong. A mispredicted branch withdraws the newest issued message with a cancel pulse, and the run count is restored so that the instructions before and after the false branch form one run again. An exception can withdraw several issued messages at once. The block remembers the newest few issued messages and emits one cancel pulse per cycle for them, newest first. Message formatting and queueing are done downstream.

Top module: `flush_trace_tracker`

## Requirements
- R1: After reset both pulse outputs are low, the count is zero, the list of issued messages is empty, and the first message carries identifier 0.
- R2: Fetch codes 1, 2 and 3 each add one to the count. Codes 0 and 4 to 7 add nothing.
- R3: Each cycle the count first drops by `flush_cnt` and stops at zero, then any increment is added. The count saturates at 2^SEQ_W-1.
- R4: `branch_taken` gives a one-cycle `msg_valid` pulse on the following cycle. `msg_seq` is the count after that cycle's flush deduction, and the fetch code of that cycle is not counted. The count then restarts at zero.
- R5: Message identifiers start at 0 and rise by one with every message, modulo 2^ID_W.
- R6: `mispredict` gives a `cancel_valid` pulse on the following cycle carrying the newest listed identifier, and removes that entry from the list. The count becomes the entry's carried count plus the count after flush deduction, saturating. With an empty list there is no pulse, and the count becomes the count after flush deduction. The fetch code is ignored in that cycle.
- R7: `exception` with `exc_kill_n` = n cancels min(n, listed entries) of the newest entries. It emits one pulse per consecutive cycle, starting on the following cycle, newest first. The count restarts at zero. The user must not raise `exception` or `mispredict` while such a burst still has pulses to come.
- R8: The list keeps the DEPTH newest messages. A new message when the list is full drops the oldest entry, and that entry can no longer be cancelled.
- R9: In one cycle, `exception` overrides `mispredict`, and `mispredict` overrides `branch_taken`. An overridden indication has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_code | input | 3 | Type of instruction entering the queue this cycle |
| flush_cnt | input | FLUSH_W | Instructions flushed this cycle |
| branch_taken | input | 1 | A taken branch to report |
| mispredict | input | 1 | The newest reported branch was mispredicted |
| exception | input | 1 | An exception cancels reported branches |
| exc_kill_n | input | OCC_W | Number of reported branches the exception cancels |
| msg_valid | output | 1 | Branch message request pulse |
| msg_seq | output | SEQ_W | Sequential count carried by the message |
| msg_id | output | ID_W | Identifier of the message |
| cancel_valid | output | 1 | Cancel request pulse |
| cancel_id | output | ID_W | Identifier of the message to withdraw |

## Verification
All internal state in this block shows up at the ports, but some of it only later. A wrong run count stays hidden until the next branch message, where it shows as a wrong `msg_seq`. So every count scenario in the bench ends with a branch, and both the flush floor and the saturation are visible there. A corrupted list or identifier counter shows on the next cancel as a wrong `cancel_id`, a missing pulse or a surplus pulse. A drain fault shows within DEPTH cycles of an exception, as a gap or a reordering in the pulse stream. A scoreboard compares every pulse, in order, with a model built from the requirements.

// File: rtl/trk_pkg.sv
// Package: fetch-type codes and the decode that decides whether a code
// stands for an instruction entering the queue.
package trk_pkg;
    localparam int CODE_W = 3;
    localparam logic [CODE_W-1:0] FC_IDLE   = 3'd0;
    localparam logic [CODE_W-1:0] FC_SEQ    = 3'd1;
    localparam logic [CODE_W-1:0] FC_TARGET = 3'd2;
    localparam logic [CODE_W-1:0] FC_OTHER  = 3'd3;

    // True when the code counts as one instruction entering the queue.
    function automatic logic is_instr(input logic [CODE_W-1:0] c);
        return (c == FC_SEQ) || (c == FC_TARGET) || (c == FC_OTHER);
    endfunction
endpackage

// File: rtl/trk_seq_counter.sv
// Sequential run counter.
// Does: subtracts the flush count (floor at zero), then adds the decoded
// fetch increment, or restores from a cancelled message's count, or clears.
// Assumes: clear and restore are never both high (top gates them).
module trk_seq_counter #(
    parameter int SEQ_W   = 8,
    parameter int FLUSH_W = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [trk_pkg::CODE_W-1:0] fetch_code,
    input  logic [FLUSH_W-1:0]         flush_cnt,
    input  logic                       clear,
    input  logic                       restore,
    input  logic [SEQ_W-1:0]           restore_base,
    output logic [SEQ_W-1:0]           after_flush,
    output logic [SEQ_W-1:0]           count
);
    localparam logic [SEQ_W:0] SAT = {1'b0, {SEQ_W{1'b1}}};

    logic [SEQ_W-1:0] flush_ext;
    logic [SEQ_W:0]   wide_sum;
    logic             inc;

    // Decode the increment and take the flushed instructions off the count.
    always_comb begin
        inc       = trk_pkg::is_instr(fetch_code);
        flush_ext = {{(SEQ_W-FLUSH_W){1'b0}}, flush_cnt};
        after_flush = (flush_ext > count) ? '0 : count - flush_ext;
        if (restore)
            wide_sum = {1'b0, restore_base} + {1'b0, after_flush};
        else
            wide_sum = {1'b0, after_flush} + (SEQ_W+1)'(inc);
    end

    // Register the next count: clear, else saturated sum.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (clear)
            count <= '0;
        else if (wide_sum > SAT)
            count <= SAT[SEQ_W-1:0];
        else
            count <= wide_sum[SEQ_W-1:0];
    end

    a_r4_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> count == '0);
    a_r3_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (!restore && !clear) |=> ({1'b0, count} <= {1'b0, $past(count)} + (SEQ_W+1)'(1)));
    a_r3_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (!restore && !clear && inc && flush_cnt == '0 && count == SAT[SEQ_W-1:0])
        |=> count == SAT[SEQ_W-1:0]);
endmodule

// File: rtl/trk_branch_list.sv
// List of issued branch messages, with the cancel pulse generator.
// Does: pushes {id, count} per issued message and drops the oldest when
// full; pops the newest on a mispredict; on an exception, removes up to
// kill_n newest entries and emits them one per cycle, newest first.
// Assumes: pop_one/kill not raised while a burst has pulses pending;
// push never coincides with pop_one or kill (top gates them).
module trk_branch_list #(
    parameter int DEPTH = 4,
    parameter int SEQ_W = 8,
    parameter int ID_W  = 3,
    parameter int OCC_W = $clog2(DEPTH+1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [SEQ_W-1:0] push_seq,
    input  logic [ID_W-1:0]  push_id,
    input  logic             pop_one,
    input  logic             kill,
    input  logic [OCC_W-1:0] kill_n,
    output logic [SEQ_W-1:0] top_seq,
    output logic             has_entry,
    output logic             cancel_valid,
    output logic [ID_W-1:0]  cancel_id
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int DRN_N = (DEPTH > 1) ? DEPTH - 1 : 1;

    logic [ID_W-1:0]  ent_id  [DEPTH];
    logic [SEQ_W-1:0] ent_seq [DEPTH];
    logic [OCC_W-1:0] occ;
    logic [OCC_W-1:0] top_pos;
    logic [OCC_W-1:0] kill_take;
    logic [ID_W-1:0]  drn_id   [DRN_N];
    logic [ID_W-1:0]  drn_load [DRN_N];
    logic [OCC_W-1:0] drn_left;

    // Locate the newest entry and clamp the exception's cancel count.
    always_comb begin
        has_entry = (occ != '0);
        top_pos   = occ - OCC_W'(1);
        top_seq   = has_entry ? ent_seq[top_pos[IDX_W-1:0]] : '0;
        kill_take = (kill_n > occ) ? occ : kill_n;
    end

    // Gather the entries below the newest, in the order they will drain.
    always_comb begin
        for (int j = 0; j < DRN_N; j++) begin
            int src;
            src = int'(occ) - 2 - j;
            drn_load[j] = (src >= 0) ? ent_id[src[IDX_W-1:0]] : '0;
        end
    end

    // Maintain occupancy and entry storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ <= '0;
        end else if (kill) begin
            occ <= occ - kill_take;
        end else if (pop_one && has_entry) begin
            occ <= occ - OCC_W'(1);
        end else if (push) begin
            if (occ == OCC_W'(DEPTH)) begin
                for (int k = 0; k < DEPTH-1; k++) begin
                    ent_id[k]  <= ent_id[k+1];
                    ent_seq[k] <= ent_seq[k+1];
                end
                ent_id[DEPTH-1]  <= push_id;
                ent_seq[DEPTH-1] <= push_seq;
            end else begin
                ent_id[occ[IDX_W-1:0]]  <= push_id;
                ent_seq[occ[IDX_W-1:0]] <= push_seq;
                occ <= occ + OCC_W'(1);
            end
        end
    end

    // Produce cancel pulses: immediate one on kill/pop, then the drain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cancel_valid <= 1'b0;
            cancel_id    <= '0;
            drn_left     <= '0;
        end else if (kill && kill_take != '0) begin
            cancel_valid <= 1'b1;
            cancel_id    <= ent_id[top_pos[IDX_W-1:0]];
            drn_id       <= drn_load;
            drn_left     <= kill_take - OCC_W'(1);
        end else if (pop_one && has_entry && !kill) begin
            cancel_valid <= 1'b1;
            cancel_id    <= ent_id[top_pos[IDX_W-1:0]];
        end else if (drn_left != '0) begin
            cancel_valid <= 1'b1;
            cancel_id    <= drn_id[0];
            for (int k = 0; k < DRN_N-1; k++)
                drn_id[k] <= drn_id[k+1];
            drn_left <= drn_left - OCC_W'(1);
        end else begin
            cancel_valid <= 1'b0;
        end
    end

    a_r8_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= OCC_W'(DEPTH));
    a_r8_full_stays_full: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !kill && !pop_one && occ == OCC_W'(DEPTH)) |=> occ == OCC_W'(DEPTH));
    a_r6_pop_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_one && !kill && has_entry) |=> (cancel_valid && occ == $past(occ) - OCC_W'(1)));
    a_r7_drain_continues: assert property (@(posedge clk) disable iff (!rst_n)
        (drn_left != '0) |=> cancel_valid);
    a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        (drn_left != '0) |-> (!kill && !pop_one));
endmodule

// File: rtl/flush_trace_tracker.sv
// Top: flush and sequential count tracker for program trace.
// Does: arbitrates exception > mispredict > branch, issues branch message
// requests with the run count and a rolling id, and routes cancels.
// Assumes: no mispredict/exception while an exception burst is draining.
module flush_trace_tracker #(
    parameter  int SEQ_W   = 8,
    parameter  int ID_W    = 3,
    parameter  int DEPTH   = 4,
    parameter  int FLUSH_W = 2,
    localparam int OCC_W   = $clog2(DEPTH+1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [trk_pkg::CODE_W-1:0] fetch_code,
    input  logic [FLUSH_W-1:0]         flush_cnt,
    input  logic                       branch_taken,
    input  logic                       mispredict,
    input  logic                       exception,
    input  logic [OCC_W-1:0]           exc_kill_n,
    output logic                       msg_valid,
    output logic [SEQ_W-1:0]           msg_seq,
    output logic [ID_W-1:0]            msg_id,
    output logic                       cancel_valid,
    output logic [ID_W-1:0]            cancel_id
);
    logic             exc_eff, mp_eff, br_eff;
    logic [SEQ_W-1:0] after_flush, count, top_seq, base_seq;
    logic             has_entry;
    logic [ID_W-1:0]  id_ctr;

    // Priority among the three indications.
    always_comb begin
        exc_eff  = exception;
        mp_eff   = mispredict & ~exception;
        br_eff   = branch_taken & ~mispredict & ~exception;
        base_seq = has_entry ? top_seq : '0;
    end

    trk_seq_counter #(.SEQ_W(SEQ_W), .FLUSH_W(FLUSH_W)) u_count (
        .clk(clk), .rst_n(rst_n), .fetch_code(fetch_code), .flush_cnt(flush_cnt),
        .clear(br_eff | exc_eff), .restore(mp_eff), .restore_base(base_seq),
        .after_flush(after_flush), .count(count)
    );

    trk_branch_list #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .ID_W(ID_W), .OCC_W(OCC_W)) u_list (
        .clk(clk), .rst_n(rst_n), .push(br_eff), .push_seq(after_flush),
        .push_id(id_ctr), .pop_one(mp_eff), .kill(exc_eff), .kill_n(exc_kill_n),
        .top_seq(top_seq), .has_entry(has_entry),
        .cancel_valid(cancel_valid), .cancel_id(cancel_id)
    );

    // Register the branch message request and advance the id.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_valid <= 1'b0;
            msg_seq   <= '0;
            msg_id    <= '0;
            id_ctr    <= '0;
        end else begin
            msg_valid <= br_eff;
            if (br_eff) begin
                msg_seq <= after_flush;
                msg_id  <= id_ctr;
                id_ctr  <= id_ctr + ID_W'(1);
            end
        end
    end

    a_r9_exc_blocks_msg: assert property (@(posedge clk) disable iff (!rst_n)
        exception |=> !msg_valid);
    a_r9_mp_blocks_msg: assert property (@(posedge clk) disable iff (!rst_n)
        mispredict |=> !msg_valid);
    a_r5_id_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && $past(msg_valid)) |-> msg_id == $past(msg_id) + ID_W'(1));
    a_r4_msg_pulse_count: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> count == '0);
endmodule

// File: tb/flush_trace_tracker_test.sv
`timescale 1ns/1ps
module flush_trace_tracker_test;
    localparam int SEQ_W = 8, ID_W = 3, DEPTH = 4, FLUSH_W = 2, OCC_W = 3;
    localparam int MAXC = 255;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n;
    logic [2:0] fetch_code;
    logic [FLUSH_W-1:0] flush_cnt;
    logic branch_taken, mispredict, exception;
    logic [OCC_W-1:0] exc_kill_n;
    logic msg_valid, cancel_valid;
    logic [SEQ_W-1:0] msg_seq;
    logic [ID_W-1:0] msg_id, cancel_id;

    flush_trace_tracker uut (
        .clk(clk), .rst_n(rst_n), .fetch_code(fetch_code), .flush_cnt(flush_cnt),
        .branch_taken(branch_taken), .mispredict(mispredict), .exception(exception),
        .exc_kill_n(exc_kill_n), .msg_valid(msg_valid), .msg_seq(msg_seq),
        .msg_id(msg_id), .cancel_valid(cancel_valid), .cancel_id(cancel_id)
    );

    int checks = 0, fails = 0;
    bit done = 0;
    int m_cnt = 0, m_id = 0;
    int stk_id[$], stk_seq[$];
    int em_seq[$], em_id[$], ec_id[$];
    string em_req[$], ec_req[$];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Driver: apply one cycle of inputs and push what the model expects.
    task automatic step(input int code, input int flush, input bit br, input bit mp,
                        input bit exc, input int kn, input string req);
        int af, n, base;
        @(negedge clk);
        fetch_code = 3'(code); flush_cnt = 2'(flush);
        branch_taken = br; mispredict = mp; exception = exc; exc_kill_n = 3'(kn);
        af = (m_cnt > flush) ? m_cnt - flush : 0;
        if (exc) begin
            n = (kn > stk_id.size()) ? stk_id.size() : kn;
            for (int i = 0; i < n; i++) begin
                ec_id.push_back(stk_id.pop_back());
                void'(stk_seq.pop_back());
                ec_req.push_back({req, " R7"});
            end
            m_cnt = 0;
        end else if (mp) begin
            base = 0;
            if (stk_id.size() > 0) begin
                ec_id.push_back(stk_id.pop_back());
                base = stk_seq.pop_back();
                ec_req.push_back({req, " R6"});
            end
            m_cnt = (base + af > MAXC) ? MAXC : base + af;
        end else if (br) begin
            em_seq.push_back(af); em_id.push_back(m_id); em_req.push_back(req);
            stk_id.push_back(m_id); stk_seq.push_back(af);
            if (stk_id.size() > DEPTH) begin
                void'(stk_id.pop_front()); void'(stk_seq.pop_front());
            end
            m_id = (m_id + 1) % (1 << ID_W);
            m_cnt = 0;
        end else begin
            m_cnt = af + ((code >= 1 && code <= 3) ? 1 : 0);
            if (m_cnt > MAXC) m_cnt = MAXC;
        end
        @(posedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) step(0, 0, 0, 0, 0, 0, "");
    endtask

    task automatic seqs(input int n);
        repeat (n) step(1, 0, 0, 0, 0, 0, "");
    endtask

    // Monitor: pop and compare each pulse as it appears.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (msg_valid) begin
                if (em_seq.size() == 0) check(0, "R4 unexpected message", msg_seq, -1);
                else begin
                    string r; int s, i;
                    s = em_seq.pop_front(); i = em_id.pop_front(); r = em_req.pop_front();
                    check(msg_seq == s, {r, " msg_seq"}, msg_seq, s);
                    check(msg_id == i, {r, " R5 msg_id"}, msg_id, i);
                end
            end
            if (cancel_valid) begin
                if (ec_id.size() == 0) check(0, "R6/R7 unexpected cancel", cancel_id, -1);
                else begin
                    string r; int i;
                    i = ec_id.pop_front(); r = ec_req.pop_front();
                    check(cancel_id == i, {r, " cancel_id"}, cancel_id, i);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 0; fetch_code = 0; flush_cnt = 0;
        branch_taken = 0; mispredict = 0; exception = 0; exc_kill_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(msg_valid == 0, "R1 msg_valid in reset", msg_valid, 0);
        check(cancel_valid == 0, "R1 cancel_valid in reset", cancel_valid, 0);
        rst_n = 1;
        step(0, 0, 1, 0, 0, 0, "R1 first message");
        // R2: codes 1..3 count, 0 and 4..7 do not
        for (int c = 0; c < 8; c++) step(c, 0, 0, 0, 0, 0, "");
        step(1, 0, 0, 0, 0, 0, "");
        step(0, 0, 1, 0, 0, 0, "R2 code decode");
        // R3: flush deduction and floor
        seqs(5);
        step(1, 2, 0, 0, 0, 0, "");
        step(0, 3, 0, 0, 0, 0, "");
        step(1, 3, 0, 0, 0, 0, "");
        step(0, 3, 0, 0, 0, 0, "");
        step(1, 0, 0, 0, 0, 0, "");
        step(0, 1, 1, 0, 0, 0, "R3 floor");
        seqs(6);
        step(0, 3, 1, 0, 0, 0, "R4 flush in branch cycle");
        // R3: saturation
        seqs(300);
        step(0, 0, 1, 0, 0, 0, "R3 saturation");
        seqs(260);
        step(0, 3, 1, 0, 0, 0, "R3 saturation then flush");
        // R6: mispredict restores count
        seqs(3);
        step(0, 0, 1, 0, 0, 0, "R6 branch");
        seqs(2);
        step(1, 2, 0, 1, 0, 0, "R6 mispredict");
        step(1, 0, 0, 0, 0, 0, "");
        step(0, 0, 1, 0, 0, 0, "R6 restored count");
        // R7: exception bursts
        step(0, 0, 0, 0, 1, 4, "R7 clear list");
        idle(5);
        seqs(1); step(0, 0, 1, 0, 0, 0, "R7 setup a");
        seqs(2); step(0, 0, 1, 0, 0, 0, "R7 setup b");
        seqs(3); step(0, 0, 1, 0, 0, 0, "R7 setup c");
        step(1, 0, 0, 0, 1, 2, "R7 kill two");
        idle(4);
        step(0, 0, 0, 0, 1, 4, "R7 kill clamped");
        idle(4);
        seqs(2); step(0, 0, 1, 0, 0, 0, "R7 count cleared");
        step(0, 0, 0, 0, 1, 4, "R7 clear list again");
        idle(5);
        // R8: overflow of the list
        for (int b = 0; b < 6; b++) begin
            seqs(b); step(0, 0, 1, 0, 0, 0, "R8 fill");
        end
        step(0, 0, 0, 0, 1, 4, "R8 kill after overflow");
        idle(5);
        seqs(3);
        step(1, 1, 0, 1, 0, 0, "R6 empty list mispredict");
        step(0, 0, 1, 0, 0, 0, "R6 empty list count");
        // R9: priority
        seqs(2);
        step(1, 0, 1, 1, 1, 1, "R9 exception wins");
        idle(3);
        seqs(2); step(0, 0, 1, 0, 0, 0, "R9 setup");
        seqs(1);
        step(0, 0, 1, 1, 0, 0, "R9 mispredict over branch");
        step(0, 0, 1, 0, 0, 0, "R9 count after mispredict");
        idle(4);
        check(em_seq.size() == 0, "R4 all messages seen", em_seq.size(), 0);
        check(ec_id.size() == 0, "R7 all cancels seen", ec_id.size(), 0);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule